// File: doc/BRIEF.md
# Serial Loader Timing Controller

This controller sits on the host side of a chain of serial-input latched output drivers. It accepts a parallel word, a bit count and a start request. It then generates four waveforms: the shift clock, the serial data, the latch strobe and an output blanking signal. Every phase of these waveforms is a whole number of system clock cycles. Each phase length comes from a nanosecond limit and the system clock period, both set by parameters, and is rounded up.

A transfer shifts the selected bits out with the most significant used bit first. When the last bit has been clocked in, word bit 0 sits in the stage nearest the serial input. The controller then waits out the clock-to-strobe spacing and pulses the strobe, which copies the chain into the driver latches. An optional blanking mode keeps the driver outputs disabled from the start of a transfer until the strobe falls. This mode suits chains whose latches are wired transparent.

Top module: `serial_loader_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards with no transfer running, all six outputs (busy, done, shift clock, serial data, strobe, blank) are low.
- R2: A transfer of length N gives exactly N shift clock rising edges. The bits are sent in the order word[N-1], then word[N-2], down to word[0]. A shift register that takes each new bit into stage 0 therefore holds word[N-1:0] when the strobe rises.
- R3: A length of 0, or a length greater than MAX_BITS, is treated as MAX_BITS.
- R4: Every shift clock low phase lasts LOW_CYC = max(ceil(T_PULSE), ceil(T_SETUP)) cycles. Every high phase lasts HIGH_CYC = max(ceil(T_PULSE), ceil(T_HOLD)) cycles. Each value is in system clock cycles, rounded up (15 and 15 with the defaults).
- R5: Serial data changes only when the shift clock falls or when a transfer begins. It is therefore stable for the whole low phase before each rising edge and for the whole high phase after it.
- R6: The strobe rises GAP_CYC = ceil(T_GAP) cycles after the last shift clock falls (30 by default), while the shift clock stays low. It stays high for STB_CYC = ceil(T_STROBE) cycles (10 by default).
- R7: Busy rises in the cycle after an accepted start and falls in the cycle in which the strobe falls. In that same cycle done is high, for one cycle only. A start request while busy has no effect: the word, length and mode then on the inputs are not used.
- R8: When blank mode is selected at start, blank is high from the cycle busy rises until busy falls. Without blank mode, blank stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Transfer request, sampled while idle |
| word_i | input | MAX_BITS | Word to send |
| len_i | input | $clog2(MAX_BITS+1) | Number of bits to send |
| blank_mode_i | input | 1 | Hold outputs blanked during the transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sclk_o | output | 1 | Shift clock to the chain |
| sdata_o | output | 1 | Serial data to the chain |
| strobe_o | output | 1 | Latch strobe to the chain |
| blank_o | output | 1 | High to disable the driver outputs |

## Verification
The hardest case to reach from the ports is a start request that arrives partway through a transfer and carries a different word, length and mode. It must leave the bit stream, the edge count and the blank level unchanged. The stimulus produces it by pulsing start about fifty cycles into selected transfers with the inverted word, another length and the opposite mode. The bench then compares the latched chain model and the blank level against the original request. Lengths of zero and lengths above the maximum are driven directly to reach the clamp.

// File: rtl/sl_pkg.sv
package sl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_STB
  } sl_state_e;

  // Nanoseconds to whole system clock cycles, rounded up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ps);
    return (ns * 1000 + per_ps - 1) / per_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sl_rst_sync.sv
module sl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sl_timer.sv
module sl_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sl_bitsel.sv
module sl_bitsel #(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                clr_i,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic                data_o,
  output logic                last_o
);
  logic [MAX_BITS-1:0] word_q, word_d;
  logic [IDX_W-1:0]    idx_q, idx_d, idx_ld;
  logic                data_q, data_d;
  logic [LEN_W-1:0]    len_eff;
  logic                en;

  always_comb begin
    if (len_i == '0 || len_i > LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
    else                                         len_eff = len_i;
    idx_ld = IDX_W'(len_eff - 1'b1);
  end

  always_comb begin
    en     = load_i | step_i | clr_i;
    word_d = word_q;
    idx_d  = idx_q;
    data_d = data_q;
    if (load_i) begin
      word_d = word_i;
      idx_d  = idx_ld;
      data_d = word_i[idx_ld];
    end else if (step_i) begin
      idx_d  = idx_q - 1'b1;
      data_d = word_q[idx_q - 1'b1];
    end else if (clr_i) begin
      data_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      data_q <= 1'b0;
    end else if (en) begin
      word_q <= word_d;
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign data_o = data_q;
  assign last_o = (idx_q == '0);
endmodule

// File: rtl/sl_seq.sv
module sl_seq
  import sl_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 15,
  parameter int unsigned HIGH_CYC = 15,
  parameter int unsigned GAP_CYC  = 30,
  parameter int unsigned STB_CYC  = 10,
  parameter int unsigned TMR_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             blank_mode_i,
  input  logic             tmr_zero_i,
  input  logic             last_bit_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             bit_load_o,
  output logic             bit_step_o,
  output logic             bit_clr_o,
  output logic             sclk_o,
  output logic             strobe_o,
  output logic             blank_o,
  output logic             busy_o,
  output logic             done_o
);
  sl_state_e st_q, st_d;
  logic sclk_q, sclk_d, stb_q, stb_d, blank_q, blank_d, busy_q, busy_d, done_q, done_d;

  always_comb begin
    st_d       = st_q;
    sclk_d     = sclk_q;
    stb_d      = stb_q;
    blank_d    = blank_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    bit_load_o = 1'b0;
    bit_step_o = 1'b0;
    bit_clr_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d       = ST_LOW;
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(LOW_CYC - 1);
        bit_load_o = 1'b1;
        busy_d     = 1'b1;
        blank_d    = blank_mode_i;
        sclk_d     = 1'b0;
      end
      ST_LOW: if (tmr_zero_i) begin
        st_d       = ST_HIGH;
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(HIGH_CYC - 1);
        sclk_d     = 1'b1;
      end
      ST_HIGH: if (tmr_zero_i) begin
        sclk_d     = 1'b0;
        tmr_load_o = 1'b1;
        if (last_bit_i) begin
          st_d      = ST_GAP;
          tmr_val_o = TMR_W'(GAP_CYC - 1);
          bit_clr_o = 1'b1;
        end else begin
          st_d       = ST_LOW;
          tmr_val_o  = TMR_W'(LOW_CYC - 1);
          bit_step_o = 1'b1;
        end
      end
      ST_GAP: if (tmr_zero_i) begin
        st_d       = ST_STB;
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(STB_CYC - 1);
        stb_d      = 1'b1;
      end
      ST_STB: if (tmr_zero_i) begin
        st_d    = ST_IDLE;
        stb_d   = 1'b0;
        busy_d  = 1'b0;
        blank_d = 1'b0;
        done_d  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sclk_q  <= 1'b0;
      stb_q   <= 1'b0;
      blank_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sclk_q  <= sclk_d;
      stb_q   <= stb_d;
      blank_q <= blank_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign strobe_o = stb_q;
  assign blank_o  = blank_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/serial_loader_ctrl.sv
module serial_loader_ctrl
  import sl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_SETUP_NS    = 75,
  parameter int unsigned T_HOLD_NS     = 75,
  parameter int unsigned T_PULSE_NS    = 150,
  parameter int unsigned T_GAP_NS      = 300,
  parameter int unsigned T_STROBE_NS   = 100,
  parameter int unsigned MAX_BITS      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [MAX_BITS-1:0]          word_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] len_i,
  input  logic                         blank_mode_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         sclk_o,
  output logic                         sdata_o,
  output logic                         strobe_o,
  output logic                         blank_o
);
  localparam int unsigned LEN_W    = $clog2(MAX_BITS + 1);
  localparam int unsigned IDX_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int unsigned LOW_CYC  = max2(1, max2(ns_to_cyc(T_PULSE_NS, CLK_PERIOD_PS),
                                                  ns_to_cyc(T_SETUP_NS, CLK_PERIOD_PS)));
  localparam int unsigned HIGH_CYC = max2(1, max2(ns_to_cyc(T_PULSE_NS, CLK_PERIOD_PS),
                                                  ns_to_cyc(T_HOLD_NS, CLK_PERIOD_PS)));
  localparam int unsigned GAP_CYC  = max2(1, ns_to_cyc(T_GAP_NS, CLK_PERIOD_PS));
  localparam int unsigned STB_CYC  = max2(1, ns_to_cyc(T_STROBE_NS, CLK_PERIOD_PS));
  localparam int unsigned MAX_CYC  = max2(max2(LOW_CYC, HIGH_CYC), max2(GAP_CYC, STB_CYC));
  localparam int unsigned TMR_W    = $clog2(MAX_CYC + 1);

  logic             rst_n_int;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             bit_load, bit_step, bit_clr, last_bit;

  sl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sl_timer #(.W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sl_bitsel #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (bit_load),
    .step_i (bit_step),
    .clr_i  (bit_clr),
    .word_i (word_i),
    .len_i  (len_i),
    .data_o (sdata_o),
    .last_o (last_bit)
  );

  sl_seq #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC),
    .GAP_CYC (GAP_CYC),
    .STB_CYC (STB_CYC),
    .TMR_W   (TMR_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (start_i),
    .blank_mode_i (blank_mode_i),
    .tmr_zero_i   (tmr_zero),
    .last_bit_i   (last_bit),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .bit_load_o   (bit_load),
    .bit_step_o   (bit_step),
    .bit_clr_o    (bit_clr),
    .sclk_o       (sclk_o),
    .strobe_o     (strobe_o),
    .blank_o      (blank_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/sl_checker.sv
module sl_checker
  import sl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_SETUP_NS    = 75,
  parameter int unsigned T_HOLD_NS     = 75,
  parameter int unsigned T_PULSE_NS    = 150,
  parameter int unsigned T_GAP_NS      = 300,
  parameter int unsigned T_STROBE_NS   = 100
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic strobe_o,
  input logic blank_o
);
  localparam int unsigned LO_MIN  = max2(ns_to_cyc(T_PULSE_NS, CLK_PERIOD_PS), ns_to_cyc(T_SETUP_NS, CLK_PERIOD_PS));
  localparam int unsigned HI_MIN  = max2(ns_to_cyc(T_PULSE_NS, CLK_PERIOD_PS), ns_to_cyc(T_HOLD_NS, CLK_PERIOD_PS));
  localparam int unsigned GAP_MIN = ns_to_cyc(T_GAP_NS, CLK_PERIOD_PS);
  localparam int unsigned STB_MIN = ns_to_cyc(T_STROBE_NS, CLK_PERIOD_PS);

  logic [15:0] lo_run, hi_run, gap_run, stb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run  <= '0;
      hi_run  <= '0;
      gap_run <= '0;
      stb_run <= '0;
    end else begin
      lo_run  <= (busy_o && !sclk_o) ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : '0;
      hi_run  <= sclk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      gap_run <= (busy_o && !sclk_o && !strobe_o) ? ((gap_run == 16'hFFFF) ? gap_run : gap_run + 1'b1) : '0;
      stb_run <= strobe_o ? ((stb_run == 16'hFFFF) ? stb_run : stb_run + 1'b1) : '0;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !strobe_o));
  a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (32'(lo_run) >= LO_MIN));
  a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (32'(hi_run) >= HI_MIN));
  a_r5_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  a_r5_data_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdata_o));
  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> (!sclk_o && 32'(gap_run) >= GAP_MIN));
  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> (32'(stb_run) >= STB_MIN));
  a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && $past(strobe_o)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_blank_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !blank_o);
endmodule

bind serial_loader_ctrl sl_checker #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .T_SETUP_NS   (T_SETUP_NS),
  .T_HOLD_NS    (T_HOLD_NS),
  .T_PULSE_NS   (T_PULSE_NS),
  .T_GAP_NS     (T_GAP_NS),
  .T_STROBE_NS  (T_STROBE_NS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .strobe_o (strobe_o),
  .blank_o  (blank_o)
);

// File: tb/tb_serial_loader_ctrl.sv
module tb_serial_loader_ctrl;
  localparam int CLK_NS = 10;
  localparam int MAXB   = 32;
  localparam int LW     = 6;
  localparam int EXP_LOW  = 15;  // max(ceil(150/10), ceil(75/10))
  localparam int EXP_HIGH = 15;
  localparam int EXP_GAP  = 30;  // ceil(300/10)
  localparam int EXP_STB  = 10;  // ceil(100/10)

  logic clk = 1'b0;
  logic rst_n, start, mode;
  logic [MAXB-1:0] word;
  logic [LW-1:0]   len;
  logic busy, done, sclk, sdata, stb, blank;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  serial_loader_ctrl #(.CLK_PERIOD_PS(CLK_NS*1000), .MAX_BITS(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(word), .len_i(len),
    .blank_mode_i(mode), .busy_o(busy), .done_o(done), .sclk_o(sclk),
    .sdata_o(sdata), .strobe_o(stb), .blank_o(blank)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- waveform monitor, samples on falling edges ----------------
  bit mon_on = 1'b0;
  bit mode_exp = 1'b0;
  logic p_sclk = 0, p_stb = 0, p_busy = 0, p_sdata = 0, p_done = 0;
  int lo_cnt = 0, hi_cnt = 0, stb_cnt = 0, rises = 0;
  logic [MAXB-1:0] chain = '0, latch = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy && !p_busy) begin rises = 0; lo_cnt = 0; end
      if (sdata != p_sdata)
        check((!sclk && p_sclk) || (busy && !p_busy), "R5", "data changed off a falling edge", sdata, p_sdata);
      if (sclk && !p_sclk) begin
        check(lo_cnt == EXP_LOW, "R4", "low phase cycles", lo_cnt, EXP_LOW);
        check(blank == mode_exp, "R8", "blank while shifting", blank, mode_exp);
        rises++;
        chain = {chain[MAXB-2:0], sdata};
        hi_cnt = 0;
      end
      if (!sclk && p_sclk) begin
        check(hi_cnt == EXP_HIGH, "R4", "high phase cycles", hi_cnt, EXP_HIGH);
        lo_cnt = 0;
      end
      if (stb && !p_stb) begin
        check(lo_cnt == EXP_GAP && !sclk, "R6", "clock-to-strobe cycles", lo_cnt, EXP_GAP);
        latch = chain;
        stb_cnt = 0;
      end
      if (!stb && p_stb) begin
        check(stb_cnt == EXP_STB, "R6", "strobe width", stb_cnt, EXP_STB);
        check(done && !busy && !blank, "R7", "done/busy/blank at strobe fall",
              {done, busy, blank}, 3'b100);
      end
      if (done && p_done) check(1'b0, "R7", "done longer than one cycle", 2, 1);
      if (busy && !sclk && !stb) lo_cnt++;
      if (sclk) hi_cnt++;
      if (stb) stb_cnt++;
    end
    p_sclk = sclk; p_stb = stb; p_busy = busy; p_sdata = sdata; p_done = done;
  end

  function automatic int eff_len(input int l);
    return (l == 0 || l > MAXB) ? MAXB : l;
  endfunction

  function automatic logic [MAXB-1:0] low_mask(input int n);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    return m[MAXB-1:0];
  endfunction

  task automatic xfer(input logic [MAXB-1:0] w, input int l, input bit m, input bit poke);
    int  n = eff_len(l);
    bit  got = 1'b0;
    @(negedge clk);
    word = w; len = LW'(l); mode = m; mode_exp = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && blank == m, "R7", "busy/blank after start", {busy, blank}, {1'b1, m});
    if (poke) begin
      repeat (50) @(negedge clk);
      word = ~w; len = LW'(eff_len(l) == 1 ? 3 : 1); mode = ~m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    check(got, "R7", "done seen", got, 1);
    check(rises == n, "R2", "shift clock edges", rises, n);
    if (l == 0 || l > MAXB) check(rises == MAXB, "R3", "clamped length", rises, MAXB);
    check((latch & low_mask(n)) == (w & low_mask(n)), "R2", "chain content",
          latch & low_mask(n), w & low_mask(n));
    if (poke) check(rises == n && (latch & low_mask(n)) == (w & low_mask(n)),
                    "R7", "start while busy ignored", rises, n);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; start = 1'b0; word = '0; len = '0; mode = 1'b0;
    repeat (3) @(negedge clk);
    check({busy, done, sclk, sdata, stb, blank} == 6'b0, "R1", "outputs in reset",
          {busy, done, sclk, sdata, stb, blank}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({busy, done, sclk, sdata, stb, blank} == 6'b0, "R1", "outputs idle after reset",
          {busy, done, sclk, sdata, stb, blank}, 0);
    mon_on = 1'b1;

    xfer(32'hA5C3_0F96, 32, 1'b0, 1'b0);
    xfer(32'h0000_0001, 1, 1'b1, 1'b0);
    xfer(32'hFFFF_FFFF, 0, 1'b1, 1'b0);   // R3 zero length
    xfer(32'h1357_9BDF, 45, 1'b0, 1'b0);  // R3 over-long length
    xfer(32'h0000_005A, 7, 1'b1, 1'b1);   // R7 start while busy
    xfer(32'h8000_0001, 2, 1'b0, 1'b1);
    xfer(32'h5555_AAAA, 31, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check({busy, sclk, stb, blank} == 4'b0, "R1", "idle between transfers",
          {busy, sclk, stb, blank}, 0);

    for (int k = 0; k < 24; k++) begin
      xfer($urandom(), $urandom_range(1, MAXB), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule